// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block is a bank of pulse-width modulators that software drives through a small synchronous register bus. Each channel has one 32-bit control word. The word holds an enable flag, an 8-bit high-time count and a 13-bit clock divider. A running channel first divides the system clock by its divider value plus one, which gives a tick. Every PWM period is exactly 256 ticks long, and the output is high for the first `duty` ticks of each period.

Software may change the duty and the divider while a channel runs, as long as the enable flag stays set in the same write. The new values are kept as pending settings. The working copy is replaced only when the current period ends, so a mid-period write never produces a short or stretched pulse. Writing zero to a control word stops the channel and clears its settings. The channel count is a parameter: four by default, and a one-channel build is also supported.

Top module: `pwm_bank`

## Requirements
- R1: A control word keeps the enable flag at bit 31, the duty count at bits 23:16 and the divider at bits 12:0. A read returns the last value written to those fields, with all other bits zero (writing 0xFFFFFFFF reads back as 0x80FF1FFF).
- R2: Channel n's control word is at byte address 16·n. Reads of any other address (a non-zero low nibble, or a channel index of NUM_CH or above) return zero, and writes to those addresses change no channel.
- R3: While a channel runs, each tick lasts exactly divider+1 clock cycles.
- R4: A period is 256 ticks. The output is high for ticks 0 to duty−1 and low for the rest of the period.
- R5: Enabling a stopped channel starts a new period at tick 0. The output is high in the first cycle after the write when duty is non-zero.
- R6: While the enable flag is clear, the output is low and both counters are held at zero. A later enable restarts the period from tick 0.
- R7: A write that keeps the enable flag set on a running channel reads back at once. Its duty and divider take effect only from the start of the next period.
- R8: A duty of 0 keeps the output low at all times. A duty of 255 makes the output low only during tick 255 of each period.
- R9: Writing all zeros to a control word stops that channel, drives its output low and reads back as zero.
- R10: With NUM_CH = 1, channel 0 behaves as above, and address 16 reads as zero.
- R11: After reset, every control word reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counters advance on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address for a read or a write |
| bus_we | input | 1 | Write strobe; the write takes effect on the rising clock edge |
| bus_wdata | input | 32 | Data to write |
| bus_rdata | output | 32 | Read data for `bus_addr`, available in the same cycle |
| pwm_out | output | NUM_CH | One modulated output per channel |

## Verification
The bench builds two instances at the same time. The first uses the default NUM_CH = 4, where several channels run at once with different dividers and the address decode can be probed above the last channel. The second uses NUM_CH = 1, where address 16 already falls outside the map. Dividers are kept between 0 and 3, so complete 256-tick periods, including a period boundary that applies pending values, fit in a few thousand cycles and each output is compared against a closed-form expectation in every cycle. The 13-bit divider field is exercised at its full value of 8191 only for read-back and start-up, because a whole period at that setting would take about two million cycles.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WORD_W      = 32;
  localparam int EN_BIT      = 31;
  localparam int DUTY_LSB    = 16;
  localparam int DUTY_W      = 8;
  localparam int SCALE_LSB   = 0;
  localparam int SCALE_W     = 13;
  localparam int STRIDE_LOG2 = 4;

  typedef struct packed {
    logic               en;
    logic [DUTY_W-1:0]  duty;
    logic [SCALE_W-1:0] scale;
  } chan_cfg_t;

  // Extract the defined fields from a bus word; other bits are dropped.
  function automatic chan_cfg_t unpack_word(input logic [WORD_W-1:0] w);
    chan_cfg_t c;
    c.en    = w[EN_BIT];
    c.duty  = w[DUTY_LSB +: DUTY_W];
    c.scale = w[SCALE_LSB +: SCALE_W];
    return c;
  endfunction

  // Build a read-back word; undefined bits are zero.
  function automatic logic [WORD_W-1:0] pack_word(input chan_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[EN_BIT]                = c.en;
    w[DUTY_LSB +: DUTY_W]    = c.duty;
    w[SCALE_LSB +: SCALE_W]  = c.scale;
    return w;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int SCALE_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [SCALE_W-1:0] limit,
  output logic               tick_stb
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [SCALE_W-1:0] cnt_q;

  // One strobe every limit+1 cycles while running.
  assign tick_stb = run && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick_stb) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_period.sv
module pwm_period #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick_stb,
  input  logic [DUTY_W-1:0] duty,
  output logic              wrap,
  output logic              level
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DUTY_W-1:0] tick_q;

  // Last tick of the period is finishing on this edge.
  assign wrap  = tick_stb && (tick_q == {DUTY_W{1'b1}});
  assign level = run && (tick_q < duty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else if (!run) begin
      tick_q <= '0;
    end else if (tick_stb) begin
      tick_q <= tick_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  chan_cfg_t         wr_cfg,
  output chan_cfg_t         cfg_o,
  output logic [DUTY_W-1:0] act_duty_o,
  output logic              en_o,
  output logic              tick_o,
  output logic              wrap_o,
  output logic              pwm_o
);
  timeunit 1ns;
  timeprecision 1ps;

  chan_cfg_t          cfg_q;
  logic [DUTY_W-1:0]  act_duty_q;
  logic [SCALE_W-1:0] act_scale_q;
  logic               direct_load;
  logic               wrap;
  logic               tick_stb;
  chan_cfg_t          load_src;

  // Stopped channel or a write that stops it: working copy follows at once.
  assign direct_load = wr_en && (!cfg_q.en || !wr_cfg.en);
  // At a period boundary a same-cycle write wins over the pending copy.
  assign load_src    = wr_en ? wr_cfg : cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      act_duty_q  <= '0;
      act_scale_q <= '0;
    end else begin
      if (wr_en) begin
        cfg_q <= wr_cfg;
      end
      if (direct_load || wrap) begin
        act_duty_q  <= load_src.duty;
        act_scale_q <= load_src.scale;
      end
    end
  end

  pwm_prescaler #(.SCALE_W(SCALE_W)) u_prescaler (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (cfg_q.en),
    .limit    (act_scale_q),
    .tick_stb (tick_stb)
  );

  pwm_period #(.DUTY_W(DUTY_W)) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (cfg_q.en),
    .tick_stb (tick_stb),
    .duty     (act_duty_q),
    .wrap     (wrap),
    .level    (pwm_o)
  );

  assign cfg_o      = cfg_q;
  assign act_duty_o = act_duty_q;
  assign en_o       = cfg_q.en;
  assign tick_o     = tick_stb;
  assign wrap_o     = wrap;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int IDX_W = ADDR_W - STRIDE_LOG2;

  logic [IDX_W-1:0]                addr_idx;
  logic                            addr_hit;
  chan_cfg_t                       wr_cfg;
  logic [NUM_CH-1:0]               ch_wr;
  logic [NUM_CH-1:0]               ch_en;
  logic [NUM_CH-1:0]               ch_tick;
  logic [NUM_CH-1:0]               ch_wrap;
  logic [NUM_CH-1:0][DUTY_W-1:0]   ch_duty_act;
  logic [NUM_CH-1:0][WORD_W-1:0]   ch_word;

  assign addr_idx = bus_addr[ADDR_W-1:STRIDE_LOG2];
  assign addr_hit = (bus_addr[STRIDE_LOG2-1:0] == '0) && (int'(addr_idx) < NUM_CH);
  assign wr_cfg   = unpack_word(bus_wdata);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    chan_cfg_t cfg_g;

    assign ch_wr[g] = bus_we && addr_hit && (addr_idx == IDX_W'(g));

    pwm_channel u_channel (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (ch_wr[g]),
      .wr_cfg     (wr_cfg),
      .cfg_o      (cfg_g),
      .act_duty_o (ch_duty_act[g]),
      .en_o       (ch_en[g]),
      .tick_o     (ch_tick[g]),
      .wrap_o     (ch_wrap[g]),
      .pwm_o      (pwm_out[g])
    );

    assign ch_word[g] = pack_word(cfg_g);
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_hit && (addr_idx == IDX_W'(i))) begin
        bus_rdata = ch_word[i];
      end
    end
  end
endmodule

// File: rtl/pwm_bank_checker.sv
module pwm_bank_checker
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          addr_hit,
  input logic [31:0]                   bus_rdata,
  input logic [NUM_CH-1:0]             ch_en,
  input logic [NUM_CH-1:0]             ch_tick,
  input logic [NUM_CH-1:0]             ch_wrap,
  input logic [NUM_CH-1:0]             ch_wr,
  input logic [NUM_CH-1:0][DUTY_W-1:0] ch_duty_act,
  input logic [NUM_CH-1:0]             pwm_out
);
  timeunit 1ns;
  timeprecision 1ps;

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> (bus_rdata == 32'h0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R6
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |-> !pwm_out[i]);

    // R8
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_duty_act[i] == '0) |-> !pwm_out[i]);

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[i] && !ch_wrap[i] && !ch_wr[i]) |=> $stable(ch_duty_act[i]));

    // R4
    wrap_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_wrap[i] |-> ch_tick[i]);

    // R5
    start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ch_en[i]) && (ch_duty_act[i] != '0)) |-> pwm_out[i]);
  end
endmodule

bind pwm_bank pwm_bank_checker #(.NUM_CH(NUM_CH)) u_pwm_bank_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_hit    (addr_hit),
  .bus_rdata   (bus_rdata),
  .ch_en       (ch_en),
  .ch_tick     (ch_tick),
  .ch_wrap     (ch_wrap),
  .ch_wr       (ch_wr),
  .ch_duty_act (ch_duty_act),
  .pwm_out     (pwm_out)
);

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NCH = 4;
  localparam int BIG = 32'h3FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_we1 = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] bus_rdata1;
  logic [NCH-1:0] pwm_out;
  logic [0:0]  pwm_out1;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_bank #(.NUM_CH(NCH), .ADDR_W(8)) u_pwm_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  pwm_bank #(.NUM_CH(1), .ADDR_W(8)) u_pwm_bank_single (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we1),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata1), .pwm_out(pwm_out1));

  typedef struct {
    int    inst;
    int    ch;
    bit    exp;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  // Monitor: compare every pending expectation at the falling edge.
  always @(negedge clk) begin
    exp_t it;
    bit   act;
    while (sb_q.size() > 0) begin
      it  = sb_q.pop_front();
      act = (it.inst == 0) ? pwm_out[it.ch] : pwm_out1[0];
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s inst%0d ch%0d cycle %0d: pwm actual %0b expected %0b",
                 it.tag, it.inst, it.ch, cyc, act, it.exp);
      end
    end
  end

  // Expected level k cycles after enable; settings switch at k = sw.
  function automatic bit exp_lvl(int k, int d1, int s1, int d2, int s2, int sw);
    int kk, d, s;
    if (k < sw) begin kk = k; d = d1; s = s1; end
    else begin kk = k - sw; d = d2; s = s2; end
    return ((kk % (256 * (s + 1))) / (s + 1)) < d;
  endfunction

  task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(int inst, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    if (inst == 0) bus_we = 1'b1; else bus_we1 = 1'b1;
    @(posedge clk);
    #1;
    bus_we  = 1'b0;
    bus_we1 = 1'b0;
  endtask

  task automatic rd(int inst, logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk32(tag, (inst == 0) ? bus_rdata : bus_rdata1, exp);
  endtask

  // Driver: push one expectation per cycle for n cycles.
  task automatic watch(int inst, int ch, int t0, int d1, int s1, int d2, int s2,
                       int sw, int n, string tag);
    for (int i = 0; i < n; i++) begin
      sb_q.push_back('{inst, ch, exp_lvl(cyc - t0, d1, s1, d2, s2, sw), tag});
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1, t2, t3, ts, kw, sw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    for (int c = 0; c < NCH; c++) rd(0, 8'(c * 16), 32'h0, "R11");
    chk32("R11 outputs", {28'h0, pwm_out}, 32'h0);

    // R1 field layout, R5 immediate start, R9 zero write
    wr(0, 8'h10, 32'hFFFF_FFFF);
    t1 = cyc;
    watch(0, 1, t1, 255, 8191, 255, 8191, BIG, 3, "R5");
    rd(0, 8'h10, 32'h80FF_1FFF, "R1");
    wr(0, 8'h10, 32'h0);
    rd(0, 8'h10, 32'h0, "R9");
    watch(0, 1, cyc, 0, 0, 0, 0, BIG, 10, "R9");

    // R2 decode and stride
    wr(0, 8'h44, 32'h80FF_0000);
    wr(0, 8'h08, 32'h80FF_0000);
    rd(0, 8'h00, 32'h0, "R2 alias");
    watch(0, 0, cyc, 0, 0, 0, 0, BIG, 5, "R2");
    rd(0, 8'h04, 32'h0, "R2 low nibble");
    rd(0, 8'h40, 32'h0, "R2 beyond");
    rd(0, 8'h44, 32'h0, "R2 beyond");
    wr(0, 8'h30, 32'h0000_0005);
    rd(0, 8'h30, 32'h0000_0005, "R2 stride");
    rd(0, 8'h20, 32'h0, "R2 neighbour");

    // R4 main waveform, R3 tick length
    wr(0, 8'h00, 32'h8064_0001);
    t0 = cyc;
    watch(0, 0, t0, 100, 1, 100, 1, BIG, 600, "R4");
    wr(0, 8'h10, 32'h8003_0002);
    t1 = cyc;
    watch(0, 1, t1, 3, 2, 3, 2, BIG, 780, "R3");

    // R8 duty extremes
    wr(0, 8'h20, 32'h8000_0000);
    t2 = cyc;
    watch(0, 2, t2, 0, 0, 0, 0, BIG, 300, "R8 zero");
    wr(0, 8'h30, 32'h80FF_0000);
    t3 = cyc;
    watch(0, 3, t3, 255, 0, 255, 0, BIG, 520, "R8 full");

    // R7 pending values apply at the next period
    do begin @(posedge clk); #1; end while (((cyc - t0) % 512) != 200);
    wr(0, 8'h00, 32'h8020_0000);
    kw = cyc - t0;
    sw = (kw / 512 + 1) * 512;
    rd(0, 8'h00, 32'h8020_0000, "R7 readback");
    watch(0, 0, t0, 100, 1, 32, 0, sw, (t0 + sw - cyc) + 300, "R7");

    // R6 disable and restart
    wr(0, 8'h00, 32'h0020_0000);
    rd(0, 8'h00, 32'h0020_0000, "R6 readback");
    watch(0, 0, cyc, 0, 0, 0, 0, BIG, 20, "R6 low");
    wr(0, 8'h00, 32'h8020_0000);
    t0 = cyc;
    watch(0, 0, t0, 32, 0, 32, 0, BIG, 300, "R6 restart");

    // R10 single-channel build
    wr(1, 8'h00, 32'h8010_0003);
    ts = cyc;
    watch(1, 0, ts, 16, 3, 16, 3, BIG, 1100, "R10");
    rd(1, 8'h10, 32'h0, "R10 unmapped");
    rd(1, 8'h00, 32'h8010_0003, "R10 readback");

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule